// File: doc/BRIEF.md
# Audio DAC Configuration Command Sequencer

This block produces the register writes that take a six-channel audio DAC out of reset and keep it configured while it runs. Each write is a 7-bit register address with a 9-bit data word, passed to a downstream serial shifter over a valid/ready handshake. The shifter that turns these words into pin activity sits outside the block.

A start pulse launches the full initialisation sequence. The sequence opens with a reset command, then holds off for a programmable settling time, then sets every channel pair to zero volume and programs the interface, clocking, polarity, mute and routing registers. Once initialisation is complete, the block accepts two kinds of runtime request. A stereo volume request names one of three channel pairs and carries two 8-bit levels; it becomes two writes, and only the second carries the update-latch bit. A rate request carries a one-bit rate class; it rewrites the master-clock ratio register.

Requests are handled one at a time. While a sequence is in progress, `busy_o` is held high and new requests are dropped.

Top module: `codec_cmd_seq`

## Requirements
- R1: After reset, `wr_valid_o`, `busy_o` and `init_done_o` are all 0.
- R2: A `start_i` pulse while `busy_o` is low starts initialisation, whether or not an earlier initialisation has finished. It clears `init_done_o`, and the first write is address 0x1F with data 0x000.
- R3: After the reset write (address 0x1F) is accepted, at least `SETTLE_CYCLES` clock cycles pass before `wr_valid_o` rises for the next write.
- R4: Initialisation then issues exactly 13 more writes, in this order (address←data): 0x00←0x000, 0x01←0x100, 0x04←0x000, 0x05←0x100, 0x06←0x000, 0x07←0x100, 0x03←0x022, 0x0A←0x080, 0x12←0x000, 0x15←0x000, 0x09←0x000, 0x02←0x124, 0x02←0x120. `init_done_o` goes high once the last of these is accepted.
- R5: A volume request (`vol_req_i` pulse) for pair index 0, 1 or 2 issues two writes. The base address is 0x00, 0x04 or 0x06 for pair 0, 1 or 2. The first write goes to the base address with data {1'b0, left}. The second goes to base+1 with data {1'b1, right}, where bit 8 is the latch bit.
- R6: A rate request (`rate_req_i` pulse) issues one write to address 0x0A. The data is 0x000 when `rate_high_i` is 1 (above 96 kHz, 128× master clock) and 0x080 otherwise (256× master clock).
- R7: Volume and rate requests produce no writes while `init_done_o` is 0 or `busy_o` is 1. A `start_i` pulse while `busy_o` is 1 has no effect.
- R8: A volume request with pair index 3 produces no writes and leaves `busy_o` low.
- R9: When a volume request and a rate request arrive in the same cycle, only the volume request is served. The rate request is dropped.
- R10: While `wr_valid_o` is 1 and `wr_ready_i` is 0, `wr_valid_o`, `wr_addr_o` and `wr_data_o` hold their values. Writes are issued strictly in sequence order, whatever the pattern of `wr_ready_i`.
- R11: `busy_o` rises in the cycle after a request or start is taken. It falls in the cycle after the sequence's last write is accepted. `wr_valid_o` is never 1 while `busy_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Pulse: run the initialisation sequence |
| vol_req_i | input | 1 | Pulse: stereo volume update request |
| vol_pair_i | input | 2 | Channel pair index for the volume request (3 is ignored) |
| vol_left_i | input | 8 | Left level |
| vol_right_i | input | 8 | Right level |
| rate_req_i | input | 1 | Pulse: sample-rate class change request |
| rate_high_i | input | 1 | 1 when the new rate is above 96 kHz |
| wr_valid_o | output | 1 | Write command valid |
| wr_addr_o | output | 7 | Register address of the write |
| wr_data_o | output | 9 | Register data of the write |
| wr_ready_i | input | 1 | Downstream accepts the write this cycle |
| busy_o | output | 1 | A sequence is in progress |
| init_done_o | output | 1 | Initialisation has completed |

## Verification
The assertions assume the downstream shifter may stall `wr_ready_i` for any number of cycles. They also assume request and start inputs are single-cycle pulses, sampled only on clock edges. The bench drives every pulse for exactly one cycle from a falling edge. It steers `wr_ready_i` from a deterministic pseudo-random pattern, so stalls land both on first and on second writes. It also fires requests into busy windows and before initialisation, so the acceptance rules face the corner cases they guard against.

// File: rtl/codec_cmd_pkg.sv
// codec_cmd_pkg
// Shared field widths, sequencer states and command tables for the DAC
// configuration sequencer. Assumes the 7-bit address / 9-bit data format
// of the target DAC's control words.
package codec_cmd_pkg;

    localparam int CMD_ADDR_W = 7;
    localparam int CMD_DATA_W = 9;
    localparam int LEVEL_W    = 8;
    localparam int PAIR_W     = 2;
    localparam int INIT_WRITES = 13;               // writes after the reset word
    localparam int STEP_W     = $clog2(INIT_WRITES);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RST,
        ST_WAIT,
        ST_INIT,
        ST_VOL,
        ST_RATE,
        ST_DRAIN
    } seq_state_t;

    typedef struct packed {
        logic [CMD_ADDR_W-1:0] addr;
        logic [CMD_DATA_W-1:0] data;
    } cmd_t;

    localparam logic [CMD_ADDR_W-1:0] ADDR_SOFT_RESET = 7'h1F;
    localparam logic [CMD_ADDR_W-1:0] ADDR_MCLK_RATIO = 7'h0A;
    localparam logic [CMD_DATA_W-1:0] MCLK_256FS      = 9'h080;
    localparam logic [CMD_DATA_W-1:0] MCLK_128FS      = 9'h000;
    localparam logic [CMD_DATA_W-1:0] LATCH_BIT       = 9'h100;

    // Left-side register address of a channel pair; right side is +1.
    function automatic logic [CMD_ADDR_W-1:0] pair_base(input logic [PAIR_W-1:0] pair);
        case (pair)
            2'd0:    pair_base = 7'h00;
            2'd1:    pair_base = 7'h04;
            2'd2:    pair_base = 7'h06;
            default: pair_base = 7'h00;
        endcase
    endfunction

    // Initialisation word for step idx (0 .. INIT_WRITES-1) after the reset.
    function automatic cmd_t init_word(input logic [STEP_W-1:0] idx);
        cmd_t c;
        if (idx < STEP_W'(6)) begin
            // zero-volume writes, left then right with the latch bit
            c.addr = pair_base(PAIR_W'(idx >> 1)) + CMD_ADDR_W'(idx[0]);
            c.data = idx[0] ? LATCH_BIT : '0;
        end else begin
            case (idx)
                STEP_W'(6):  c = '{addr: 7'h03, data: 9'h022};
                STEP_W'(7):  c = '{addr: ADDR_MCLK_RATIO, data: MCLK_256FS};
                STEP_W'(8):  c = '{addr: 7'h12, data: 9'h000};
                STEP_W'(9):  c = '{addr: 7'h15, data: 9'h000};
                STEP_W'(10): c = '{addr: 7'h09, data: 9'h000};
                STEP_W'(11): c = '{addr: 7'h02, data: 9'h124};
                default:     c = '{addr: 7'h02, data: 9'h120};
            endcase
        end
        return c;
    endfunction

endpackage

// File: rtl/codec_cmd_gen.sv
// codec_cmd_gen
// Combinational command source: maps the sequencer state and step to the
// address/data word to emit and flags the last word of the sequence.
// Assumes the step never exceeds the length of the active sequence.
module codec_cmd_gen
    import codec_cmd_pkg::*;
(
    input  seq_state_t          state_i,
    input  logic [STEP_W-1:0]   step_i,
    input  logic [PAIR_W-1:0]   pair_i,
    input  logic [LEVEL_W-1:0]  left_i,
    input  logic [LEVEL_W-1:0]  right_i,
    input  logic                high_i,
    output cmd_t                cmd_o,
    output logic                last_o
);

    logic [CMD_ADDR_W-1:0] base;

    // Pick the word for the current state and step.
    always_comb begin
        base   = pair_base(pair_i);
        cmd_o  = '0;
        last_o = 1'b0;
        case (state_i)
            ST_RST: begin
                cmd_o  = '{addr: ADDR_SOFT_RESET, data: '0};
                last_o = 1'b1;
            end
            ST_INIT: begin
                cmd_o  = init_word(step_i);
                last_o = (step_i == STEP_W'(INIT_WRITES-1));
            end
            ST_VOL: begin
                if (step_i == '0) begin
                    cmd_o = '{addr: base, data: {1'b0, left_i}};
                end else begin
                    cmd_o  = '{addr: base + 7'd1, data: LATCH_BIT | {1'b0, right_i}};
                    last_o = 1'b1;
                end
            end
            ST_RATE: begin
                cmd_o  = '{addr: ADDR_MCLK_RATIO, data: high_i ? MCLK_128FS : MCLK_256FS};
                last_o = 1'b1;
            end
            default: begin
                cmd_o  = '0;
                last_o = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/codec_settle_timer.sv
// codec_settle_timer
// Counts enabled cycles after a clear and pulses expire_o on the enabled
// cycle that completes CYCLES of them. Assumes CYCLES >= 1.
module codec_settle_timer #(
    parameter int CYCLES = 2500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic count_i,
    output logic expire_o
);

    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt_q;

    assign expire_o = count_i && (cnt_q == CW'(CYCLES - 1));

    // Count enabled cycles, restarting on clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            cnt_q <= '0;
        end else if (count_i && !expire_o) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/codec_wr_port.sv
// codec_wr_port
// Output register for the write handshake. A load captures a word and
// raises valid; valid drops on acceptance. Assumes load is only asserted
// while free_o is high.
module codec_wr_port
    import codec_cmd_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load_i,
    input  cmd_t                  cmd_i,
    input  logic                  ready_i,
    output logic                  free_o,
    output logic                  valid_o,
    output logic [CMD_ADDR_W-1:0] addr_o,
    output logic [CMD_DATA_W-1:0] data_o
);

    assign free_o = !valid_o || ready_i;

    // Hold the word until the receiver takes it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o <= 1'b0;
            addr_o  <= '0;
            data_o  <= '0;
        end else if (load_i) begin
            valid_o <= 1'b1;
            addr_o  <= cmd_i.addr;
            data_o  <= cmd_i.data;
        end else if (ready_i) begin
            valid_o <= 1'b0;
        end
    end

endmodule

// File: rtl/codec_cmd_seq.sv
// codec_cmd_seq
// Sequencer that emits DAC configuration writes: a full initialisation on
// start, a two-word stereo volume update, or a master-clock ratio rewrite
// on a rate-class change. One sequence runs at a time. Assumes request and
// start inputs are single-cycle pulses.
module codec_cmd_seq
    import codec_cmd_pkg::*;
#(
    parameter int SETTLE_CYCLES = 2500
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_i,
    input  logic                  vol_req_i,
    input  logic [PAIR_W-1:0]     vol_pair_i,
    input  logic [LEVEL_W-1:0]    vol_left_i,
    input  logic [LEVEL_W-1:0]    vol_right_i,
    input  logic                  rate_req_i,
    input  logic                  rate_high_i,
    output logic                  wr_valid_o,
    output logic [CMD_ADDR_W-1:0] wr_addr_o,
    output logic [CMD_DATA_W-1:0] wr_data_o,
    input  logic                  wr_ready_i,
    output logic                  busy_o,
    output logic                  init_done_o
);

    seq_state_t          state_q;
    logic [STEP_W-1:0]   step_q;
    logic [PAIR_W-1:0]   pair_q;
    logic [LEVEL_W-1:0]  left_q;
    logic [LEVEL_W-1:0]  right_q;
    logic                high_q;
    logic                in_init_q;
    logic                done_q;

    cmd_t cur_cmd;
    logic cur_last;
    logic port_free;
    logic emitting;
    logic issue;
    logic settle_clear;
    logic settle_expire;
    logic vol_take;
    logic rate_take;

    assign busy_o      = (state_q != ST_IDLE);
    assign init_done_o = done_q;

    // A write is emitted whenever a word-producing state finds the port free.
    always_comb begin
        emitting     = (state_q == ST_RST) || (state_q == ST_INIT) ||
                       (state_q == ST_VOL) || (state_q == ST_RATE);
        issue        = emitting && port_free;
        settle_clear = (state_q == ST_RST) && issue;
        vol_take     = done_q && vol_req_i && (vol_pair_i != 2'd3);
        rate_take    = done_q && rate_req_i && !vol_req_i;
    end

    codec_cmd_gen u_gen (
        .state_i (state_q),
        .step_i  (step_q),
        .pair_i  (pair_q),
        .left_i  (left_q),
        .right_i (right_q),
        .high_i  (high_q),
        .cmd_o   (cur_cmd),
        .last_o  (cur_last)
    );

    codec_settle_timer #(
        .CYCLES (SETTLE_CYCLES)
    ) u_settle (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (settle_clear),
        .count_i  ((state_q == ST_WAIT) && !wr_valid_o),
        .expire_o (settle_expire)
    );

    codec_wr_port u_port (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (issue),
        .cmd_i   (cur_cmd),
        .ready_i (wr_ready_i),
        .free_o  (port_free),
        .valid_o (wr_valid_o),
        .addr_o  (wr_addr_o),
        .data_o  (wr_data_o)
    );

    // Sequence control: accept work when idle, step through words, drain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            step_q    <= '0;
            pair_q    <= '0;
            left_q    <= '0;
            right_q   <= '0;
            high_q    <= 1'b0;
            in_init_q <= 1'b0;
            done_q    <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    step_q <= '0;
                    if (start_i) begin
                        state_q   <= ST_RST;
                        in_init_q <= 1'b1;
                        done_q    <= 1'b0;
                    end else if (vol_take) begin
                        state_q   <= ST_VOL;
                        in_init_q <= 1'b0;
                        pair_q    <= vol_pair_i;
                        left_q    <= vol_left_i;
                        right_q   <= vol_right_i;
                    end else if (rate_take) begin
                        state_q   <= ST_RATE;
                        in_init_q <= 1'b0;
                        high_q    <= rate_high_i;
                    end
                end
                ST_RST: begin
                    if (issue) begin
                        state_q <= ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (settle_expire) begin
                        state_q <= ST_INIT;
                        step_q  <= '0;
                    end
                end
                ST_INIT, ST_VOL, ST_RATE: begin
                    if (issue) begin
                        if (cur_last) begin
                            state_q <= ST_DRAIN;
                        end else begin
                            step_q <= step_q + 1'b1;
                        end
                    end
                end
                ST_DRAIN: begin
                    if (port_free) begin
                        state_q <= ST_IDLE;
                        if (in_init_q) begin
                            done_q <= 1'b1;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/codec_cmd_seq_chk.sv
// codec_cmd_seq_chk
// Property checker for codec_cmd_seq, attached by bind. Assumes requests
// and start are single-cycle pulses and wr_ready_i may stall freely.
module codec_cmd_seq_chk #(
    parameter int SETTLE_CYCLES = 2500
) (
    input logic       clk,
    input logic       rst_n,
    input logic       start_i,
    input logic       vol_req_i,
    input logic [1:0] vol_pair_i,
    input logic       rate_req_i,
    input logic       wr_valid_o,
    input logic [6:0] wr_addr_o,
    input logic [8:0] wr_data_o,
    input logic       wr_ready_i,
    input logic       busy_o,
    input logic       init_done_o
);

    localparam int GW = $clog2(SETTLE_CYCLES + 2) + 1;

    logic          armed_q;
    logic [GW-1:0] gap_q;

    // Track cycles since the reset word was accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
            gap_q   <= '0;
        end else if (wr_valid_o && wr_ready_i) begin
            armed_q <= (wr_addr_o == 7'h1F);
            gap_q   <= '0;
        end else if (armed_q && gap_q != {GW{1'b1}}) begin
            gap_q <= gap_q + 1'b1;
        end
    end

    // R3: next write waits out the settling time after the reset word
    a_r3_settle_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && wr_valid_o) |-> (gap_q >= GW'(SETTLE_CYCLES)));

    // R10: a stalled word holds steady
    a_r10_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid_o && !wr_ready_i) |=>
            (wr_valid_o && $stable(wr_addr_o) && $stable(wr_data_o)));

    // R11: no write outstanding while idle
    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !wr_valid_o);

    // R11: busy ends only with an acceptance
    a_r11_busy_end: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> $past(wr_valid_o && wr_ready_i));

    // R7 / R8: busy only starts from a start or an admissible request
    a_r7_accept_rule: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(start_i || (init_done_o &&
            ((vol_req_i && vol_pair_i != 2'd3) || rate_req_i))));

    // R4: completion follows the final acceptance with the block idle
    a_r4_done_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(init_done_o) |-> ($past(wr_valid_o && wr_ready_i) && !busy_o));

endmodule

bind codec_cmd_seq codec_cmd_seq_chk #(
    .SETTLE_CYCLES (SETTLE_CYCLES)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .vol_req_i   (vol_req_i),
    .vol_pair_i  (vol_pair_i),
    .rate_req_i  (rate_req_i),
    .wr_valid_o  (wr_valid_o),
    .wr_addr_o   (wr_addr_o),
    .wr_data_o   (wr_data_o),
    .wr_ready_i  (wr_ready_i),
    .busy_o      (busy_o),
    .init_done_o (init_done_o)
);

// File: tb/codec_cmd_seq_test.sv
module codec_cmd_seq_test;

    localparam int W = 2500;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic       vol_req_i = 1'b0;
    logic [1:0] vol_pair_i = '0;
    logic [7:0] vol_left_i = '0;
    logic [7:0] vol_right_i = '0;
    logic       rate_req_i = 1'b0;
    logic       rate_high_i = 1'b0;
    logic       wr_valid_o;
    logic [6:0] wr_addr_o;
    logic [8:0] wr_data_o;
    logic       wr_ready_i = 1'b0;
    logic       busy_o;
    logic       init_done_o;

    always #2 clk = ~clk;   // 250 MHz

    codec_cmd_seq #(.SETTLE_CYCLES(W)) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .vol_req_i(vol_req_i), .vol_pair_i(vol_pair_i),
        .vol_left_i(vol_left_i), .vol_right_i(vol_right_i),
        .rate_req_i(rate_req_i), .rate_high_i(rate_high_i),
        .wr_valid_o(wr_valid_o), .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o),
        .wr_ready_i(wr_ready_i), .busy_o(busy_o), .init_done_o(init_done_o)
    );

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    int log_n = 0;
    int hold_err = 0;
    logic [15:0] log_w [0:63];
    int          log_c [0:63];
    logic        stall_en = 1'b0;
    logic [7:0]  lfsr = 8'hA5;
    logic        prev_stall = 1'b0;
    logic [15:0] prev_word = '0;

    // expected initialisation words after the reset word: {addr7, data9}
    localparam logic [15:0] INIT_EXP [0:12] = '{
        {7'h00, 9'h000}, {7'h01, 9'h100}, {7'h04, 9'h000}, {7'h05, 9'h100},
        {7'h06, 9'h000}, {7'h07, 9'h100}, {7'h03, 9'h022}, {7'h0A, 9'h080},
        {7'h12, 9'h000}, {7'h15, 9'h000}, {7'h09, 9'h000}, {7'h02, 9'h124},
        {7'h02, 9'h120}
    };

    typedef struct packed {
        logic [1:0]  kind;   // 1 volume, 2 rate
        logic [1:0]  pair;
        logic [7:0]  left;
        logic [7:0]  right;
        logic        high;
        logic [1:0]  n;
        logic [15:0] e0;
        logic [15:0] e1;
    } vec_t;

    localparam vec_t VECS [0:5] = '{
        '{2'd1, 2'd0, 8'h12, 8'h34, 1'b0, 2'd2, {7'h00, 9'h012}, {7'h01, 9'h134}},
        '{2'd1, 2'd1, 8'hFF, 8'h00, 1'b0, 2'd2, {7'h04, 9'h0FF}, {7'h05, 9'h100}},
        '{2'd1, 2'd2, 8'h80, 8'hFF, 1'b0, 2'd2, {7'h06, 9'h080}, {7'h07, 9'h1FF}},
        '{2'd1, 2'd3, 8'h55, 8'hAA, 1'b0, 2'd0, 16'h0000, 16'h0000},
        '{2'd2, 2'd0, 8'h00, 8'h00, 1'b1, 2'd1, {7'h0A, 9'h000}, 16'h0000},
        '{2'd2, 2'd0, 8'h00, 8'h00, 1'b0, 2'd1, {7'h0A, 9'h080}, 16'h0000}
    };

    // Downstream model: drives ready, logs accepted words, watches holds.
    always @(negedge clk) begin
        cyc++;
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        if (prev_stall && (!wr_valid_o || {wr_addr_o, wr_data_o} != prev_word))
            hold_err++;
        wr_ready_i = stall_en ? (lfsr[0] | lfsr[1]) : 1'b1;
        if (wr_valid_o && wr_ready_i && log_n < 64) begin
            log_w[log_n] = {wr_addr_o, wr_data_o};
            log_c[log_n] = cyc;
            log_n++;
        end
        prev_stall = wr_valid_o && !wr_ready_i;
        prev_word  = {wr_addr_o, wr_data_o};
        if (cyc > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual cycle %0d expected below 150000", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic pulse_vol(input logic [1:0] p, input logic [7:0] l, input logic [7:0] r);
        @(negedge clk);
        vol_req_i = 1'b1; vol_pair_i = p; vol_left_i = l; vol_right_i = r;
        @(negedge clk);
        vol_req_i = 1'b0;
    endtask

    task automatic pulse_rate(input logic hi);
        @(negedge clk);
        rate_req_i = 1'b1; rate_high_i = hi;
        @(negedge clk);
        rate_req_i = 1'b0;
    endtask

    task automatic pulse_start();
        @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 10000 && busy_o; i++) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(wr_valid_o == 1'b0, "R1 valid", wr_valid_o, 0);
        check(busy_o == 1'b0, "R1 busy", busy_o, 0);
        check(init_done_o == 1'b0, "R1 done", init_done_o, 0);

        // R7: requests before initialisation are dropped
        pulse_vol(2'd0, 8'h11, 8'h22);
        pulse_rate(1'b1);
        repeat (5) @(negedge clk);
        check(log_n == 0, "R7 pre-init writes", log_n, 0);
        check(busy_o == 1'b0, "R7 pre-init busy", busy_o, 0);

        // R2 / R3 / R4: initialisation
        pulse_start();
        check(busy_o == 1'b1, "R11 busy after start", busy_o, 1);
        wait_idle();
        check(log_n == 14, "R4 init count", log_n, 14);
        check(log_w[0] == {7'h1F, 9'h000}, "R2 reset word", log_w[0], {7'h1F, 9'h000});
        check(log_c[1] - log_c[0] >= W, "R3 settle gap", log_c[1] - log_c[0], W);
        for (int i = 0; i < 13; i++)
            check(log_w[i+1] == INIT_EXP[i], "R4 init word", log_w[i+1], INIT_EXP[i]);
        check(init_done_o == 1'b1, "R4 done", init_done_o, 1);

        // R5 / R6 / R8 / R10: vector table under backpressure
        stall_en = 1'b1;
        foreach (VECS[k]) begin
            log_n = 0;
            if (VECS[k].kind == 2'd1) pulse_vol(VECS[k].pair, VECS[k].left, VECS[k].right);
            else pulse_rate(VECS[k].high);
            if (VECS[k].n == 2'd0)
                check(busy_o == 1'b0, "R8 pair3 busy", busy_o, 0);
            wait_idle();
            repeat (10) @(negedge clk);
            check(log_n == int'(VECS[k].n), "R5 R6 R8 write count", log_n, VECS[k].n);
            if (VECS[k].n >= 2'd1)
                check(log_w[0] == VECS[k].e0, "R5 R6 first word", log_w[0], VECS[k].e0);
            if (VECS[k].n == 2'd2)
                check(log_w[1] == VECS[k].e1, "R5 second word", log_w[1], VECS[k].e1);
        end

        // R7: requests and start while busy are dropped
        log_n = 0;
        pulse_vol(2'd0, 8'h01, 8'h02);
        check(busy_o == 1'b1, "R11 busy after request", busy_o, 1);
        @(negedge clk);
        vol_req_i = 1'b1; vol_pair_i = 2'd1; vol_left_i = 8'h03; vol_right_i = 8'h04;
        start_i = 1'b1; rate_req_i = 1'b1;
        @(negedge clk);
        vol_req_i = 1'b0; start_i = 1'b0; rate_req_i = 1'b0;
        wait_idle();
        check(log_n == 2, "R7 busy drop count", log_n, 2);
        check(log_w[1] == {7'h01, 9'h102}, "R7 busy drop word", log_w[1], {7'h01, 9'h102});
        check(init_done_o == 1'b1, "R7 start ignored while busy", init_done_o, 1);

        // R9: simultaneous volume and rate
        log_n = 0;
        @(negedge clk);
        vol_req_i = 1'b1; vol_pair_i = 2'd2; vol_left_i = 8'h07; vol_right_i = 8'h08;
        rate_req_i = 1'b1; rate_high_i = 1'b1;
        @(negedge clk);
        vol_req_i = 1'b0; rate_req_i = 1'b0;
        wait_idle();
        repeat (10) @(negedge clk);
        check(log_n == 2, "R9 count", log_n, 2);
        check(log_w[0] == {7'h06, 9'h007}, "R9 first", log_w[0], {7'h06, 9'h007});
        check(log_w[1] == {7'h07, 9'h108}, "R9 second", log_w[1], {7'h07, 9'h108});
        check(busy_o == 1'b0 && wr_valid_o == 1'b0, "R11 idle after", busy_o, 0);

        // R2: re-initialisation after completion
        log_n = 0;
        pulse_start();
        check(init_done_o == 1'b0, "R2 done cleared", init_done_o, 0);
        wait_idle();
        check(log_n == 14, "R2 reinit count", log_n, 14);
        check(log_w[13] == INIT_EXP[12], "R2 reinit last", log_w[13], INIT_EXP[12]);
        check(init_done_o == 1'b1, "R2 reinit done", init_done_o, 1);

        check(hold_err == 0, "R10 stalled word held", hold_err, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule